// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned operands over a series of clock cycles, one multiplier bit at a time. A pulse on `start` while the block is idle captures both operands. The block then repeats an add cycle and a shift cycle once for each multiplier bit. When the product is ready, it raises `done` for a single cycle. With the default width of 8, an 8-by-8 operation yields a 16-bit product.

The datapath has four parts: a register for the multiplicand, a right-shifting register for the multiplier, and a product register one bit wider than the result. The extra bit holds the adder carry. The fourth part is an adder that takes the upper half of the product and a gated copy of the multiplicand. A controller with four states and a step counter sequences the datapath. The counter ends the loop when it wraps. `start` and `done` are plain control pins with no back-pressure. The caller waits for `done` and then reads `result`, which holds its value until the next operation is accepted.

Top module: `seq_shadd_mul`

## Requirements
- R1: While `rst` (active high, asynchronous) is asserted, and after it is released, `result` is 0, `done` is 0 and the block is idle.
- R2: When `start` is high at a rising edge while the block is idle, the operands are accepted at that edge (E0). `done` is high in the cycle after edge E(2·W), which is E16 for W=8. It falls at the following edge.
- R3: During the `done` cycle, `result` equals `op_a` × `op_b` as unsigned numbers, using the operand values sampled at the accepting edge.
- R4: `done` is never high for two consecutive cycles.
- R5: `start` has no effect while an operation is in progress. The timing of `done` and the product of the operation already running stay unchanged.
- R6: Once an operation completes, `result` keeps the product through every idle cycle until the next `start` is accepted.
- R7: In the cycle after a `start` is accepted, `result` reads 0.
- R8: The carry out of the adder is kept. 255 × 255 gives 65025, 255 × 1 gives 255, and any operand of 0 gives 0.
- R9: A change on `op_a` or `op_b` after the accepting edge does not affect the product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Requests an operation; acted on only when idle |
| op_a | input | W (8) | Multiplier operand, scanned LSB first |
| op_b | input | W (8) | Multiplicand operand |
| result | output | 2·W (16) | Low 2·W bits of the product register |
| done | output | 1 | One-cycle pulse marking a valid `result` |

## Verification
Each fault in the controller shows up at the ports on a fixed schedule, so the bench checks `done` in every cycle from acceptance to completion. If the step counter is off or a state transition is wrong, `done` moves away from the 17th cycle after acceptance. A lost carry or a wrong shift order shows up as a wrong product during the `done` cycle. This is most visible for operands near full scale. If the operand registers or the product register are not held while busy or idle, a mid-run `start`, an operand change or a long idle gap corrupts `result`. The corrupted value is visible by the next `done` or in the very next idle cycle.

// File: rtl/shm_pkg.sv
package shm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADD  = 2'd1,
    ST_SHFT = 2'd2,
    ST_FIN  = 2'd3
  } shm_state_e;
endpackage

// File: rtl/shm_ctrl.sv
module shm_ctrl
  import shm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic init,
  output logic add_en,
  output logic shift_en,
  output logic fin
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  shm_state_e state, state_nx;
  logic [CW-1:0] step;
  logic          last_step;

  assign last_step = (step == CW'(W - 1));

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (start) state_nx = ST_ADD;
      ST_ADD:  state_nx = ST_SHFT;
      ST_SHFT: state_nx = last_step ? ST_FIN : ST_ADD;
      ST_FIN:  state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      state <= state_nx;
      if (init)          step <= '0;
      else if (shift_en) step <= step + 1'b1;
    end
  end

  assign init     = (state == ST_IDLE) && start;
  assign add_en   = (state == ST_ADD);
  assign shift_en = (state == ST_SHFT);
  assign fin      = (state == ST_FIN);

  // R2: an add cycle is always followed by a shift cycle
  p_add_then_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADD) |=> (state == ST_SHFT));
  // R2: the loop ends exactly when the counter wraps
  p_wrap_ends_loop_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHFT && last_step) |=> (state == ST_FIN));
  // R5: start has no effect outside idle
  p_busy_ignores_start_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHFT && !last_step) |=> (state == ST_ADD));
  // R4: completion returns to idle
  p_fin_to_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIN) |=> (state == ST_IDLE));
endmodule

// File: rtl/shm_operands.sv
module shm_operands #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         shift_en,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] mcand,
  output logic         mbit
);
  logic [W-1:0] mplier;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      mcand  <= '0;
      mplier <= '0;
    end else if (init) begin
      mcand  <= op_b;
      mplier <= op_a;
    end else if (shift_en) begin
      mplier <= {1'b0, mplier[W-1:1]};
    end
  end

  assign mbit = mplier[0];

  // R9: operands are held once captured
  p_mcand_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !init |=> $stable(mcand));
  p_mplier_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!init && !shift_en) |=> $stable(mplier));
endmodule

// File: rtl/shm_datapath.sv
module shm_datapath #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           init,
  input  logic           add_en,
  input  logic           shift_en,
  input  logic [W-1:0]   mcand,
  input  logic           mbit,
  output logic [2*W-1:0] result
);
  localparam int PW = 2 * W + 1;

  logic [PW-1:0] prod;
  logic [W-1:0]  partial;
  logic [W:0]    sum;

  for (genvar i = 0; i < W; i++) begin : g_gate
    assign partial[i] = mcand[i] & mbit;
  end

  assign sum = {1'b0, prod[2*W-1:W]} + {1'b0, partial};

  always_ff @(posedge clk or posedge rst) begin
    if (rst)           prod <= '0;
    else if (init)     prod <= '0;
    else if (add_en)   prod[PW-1:W] <= sum;
    else if (shift_en) prod <= {1'b0, prod[PW-1:1]};
  end

  assign result = prod[2*W-1:0];

  // R7: acceptance clears the product
  p_clear_on_start_r7: assert property (@(posedge clk) disable iff (rst)
    init |=> (prod == '0));
  // R6: product holds when no step is taken
  p_prod_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!init && !add_en && !shift_en) |=> $stable(prod));
  // R8: top bit is free before each add
  p_top_clear_r8: assert property (@(posedge clk) disable iff (rst)
    add_en |-> (prod[PW-1] == 1'b0));
endmodule

// File: rtl/seq_shadd_mul.sv
module seq_shadd_mul #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] result,
  output logic           done
);
  logic         init, add_en, shift_en, fin;
  logic [W-1:0] mcand;
  logic         mbit;

  shm_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .init(init), .add_en(add_en), .shift_en(shift_en), .fin(fin)
  );

  shm_operands #(.W(W)) u_ops (
    .clk(clk), .rst(rst), .init(init), .shift_en(shift_en),
    .op_a(op_a), .op_b(op_b), .mcand(mcand), .mbit(mbit)
  );

  shm_datapath #(.W(W)) u_dp (
    .clk(clk), .rst(rst), .init(init), .add_en(add_en),
    .shift_en(shift_en), .mcand(mcand), .mbit(mbit), .result(result)
  );

  assign done = fin;

  // R4: single-cycle done
  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5: done never coincides with acceptance
  p_done_not_init_r5: assert property (@(posedge clk) disable iff (rst)
    !(done && init));
endmodule

// File: tb/seq_shadd_mul_bench.sv
module seq_shadd_mul_bench;
  localparam int W = 8;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [2*W-1:0] result;
  logic done;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  seq_shadd_mul #(.W(W)) u_seq_shadd_mul (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .result(result), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one operation; optional busy disturbance with other operands.
  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb);
    logic [2*W-1:0] exp = a * b;
    @(negedge clk); start = 1'b1; op_a = a; op_b = b;
    @(negedge clk); start = 1'b0;
    chk("R7 cleared", result, 0);
    for (int k = 2; k <= 17; k++) begin
      if (disturb && (k == 4 || k == 9)) begin start = 1'b1; op_a = ~a; op_b = b + 8'd3; end
      if (disturb && (k == 6 || k == 11)) start = 1'b0;
      @(negedge clk);
      if (k < 17) begin
        if (done !== 1'b0) chk("R2 early done", done, 0);
      end
    end
    chk(disturb ? "R5 done timing" : "R2 done timing", done, 1);
    chk(disturb ? "R9 product" : "R3 product", result, exp);
    @(negedge clk);
    chk("R4 done falls", done, 0);
    chk("R6 hold", result, exp);
    repeat (5) @(negedge clk);
    chk("R6 hold idle", result, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 result", result, 0);
    chk("R1 done", done, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {done, result}, 0);
  endtask

  task automatic t_basic;   run_mul(8'd11, 8'd9, 0);   endtask
  task automatic t_carry;   run_mul(8'd255, 8'd255, 0); run_mul(8'd255, 8'd1, 0); endtask
  task automatic t_zero;    run_mul(8'd0, 8'd77, 0);   run_mul(8'd200, 8'd0, 0); endtask
  task automatic t_busy;    run_mul(8'd173, 8'd58, 1); endtask
  task automatic t_mixed;   run_mul(8'd128, 8'd129, 0); run_mul(8'd1, 8'd254, 0); endtask

  initial begin
    t_reset();
    t_basic();
    t_carry();
    t_zero();
    t_busy();
    t_mixed();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule